// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block is the digital control core of one contact smart card slot. A host starts a card session by pulling an active-low activation command low. The block first confirms that a card is seated and that no supply or protection flag is raised. It then switches on the card supply, the I/O driver and the card clock, in that order, with a programmable gap between steps. Once all three are on, the card reset line follows the host's reset request. Card presence comes from two switch inputs of opposite polarity, so either kind of switch can be fitted. The unused input is tied to its inactive level.

The session can end in two ways. The host can release the command, or the block can abort on its own: card removal, card-supply undervoltage, regulator-supply undervoltage (regulator supply below card supply), digital-supply undervoltage, over-current or over-temperature each force an emergency power-down. Power-down runs in reverse order with a fixed gap per step. The interrupt output has two meanings. Outside a session it shows whether a card is present. During a session a low level means a fault has aborted the session. After a fault abort the interrupt stays low and the slot is locked until the host releases the command. A digital-supply fault in the idle state holds off activation, so the sequencer only starts once that supply is good.

The analog parts (regulator, comparators, level shifters) are not in this block. They reach it as synchronized digital flags.

Top module: `scard_seq`

## Requirements
- R1: Outside a session, and one cycle after a change, irq_n_o equals pres_hi_i OR NOT pres_lo_n_i: high when a card is present, low when none is. During reset every output is 0.
- R2: A session starts only from idle, with act_n_i low, a card present and all five fault flags low. If a card is missing or any flag is set, vcc_en_o stays 0.
- R3: Activation sets vcc_en_o one cycle after the start condition is sampled. io_en_o follows ACT_GAP cycles after vcc_en_o, and clk_en_o follows ACT_GAP cycles after io_en_o.
- R4: card_rst_o stays 0 until ACT_GAP cycles after clk_en_o rises. From then on it equals rst_lvl_i with one cycle of latency.
- R5: Raising act_n_i during a session starts deactivation one cycle later. card_rst_o drops first, clk_en_o drops DEACT_GAP cycles later, io_en_o drops 2*DEACT_GAP cycles later and vcc_en_o drops 3*DEACT_GAP cycles later. Outputs that were still off stay off.
- R6: Card removal (on either presence input) or any of the five fault flags forces the same deactivation ordering from any activation step or from the active state.
- R7: During a session without a fault, irq_n_o is 1. When a fault or removal is sampled, irq_n_o goes low one cycle later, in the first cycle of deactivation.
- R8: After a fault-driven deactivation, irq_n_o stays 0 and no new session starts while act_n_i stays low, even when the fault has cleared. One cycle after act_n_i rises, the slot is idle again and irq_n_o shows presence.
- R9: vsel_o captures vsel_i in the cycle a session starts and holds that value until the next session start.
- R10: While flt_vdig_i is high in idle, activation is held off. The first cycle after it clears with act_n_i low and a card present, the session starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| act_n_i | input | 1 | Host activation command, active low |
| rst_lvl_i | input | 1 | Host-requested card reset line level |
| vsel_i | input | 1 | Card voltage select, 1 = high voltage class |
| pres_hi_i | input | 1 | Presence switch, active high |
| pres_lo_n_i | input | 1 | Presence switch, active low |
| flt_vcc_i | input | 1 | Card supply undervoltage flag |
| flt_vreg_i | input | 1 | Regulator supply below card supply flag |
| flt_vdig_i | input | 1 | Digital supply undervoltage flag |
| flt_ovc_i | input | 1 | Card over-current flag |
| flt_temp_i | input | 1 | Over-temperature flag |
| vcc_en_o | output | 1 | Card supply enable |
| vsel_o | output | 1 | Voltage class held for the session |
| io_en_o | output | 1 | Card I/O driver enable |
| clk_en_o | output | 1 | Card clock enable; clock held low when 0 |
| card_rst_o | output | 1 | Card reset line level |
| irq_n_o | output | 1 | Host interrupt, active low |

## Verification
The bench builds the block with ACT_GAP=3 and DEACT_GAP=2. With gaps that short, every activation step is reached within ten cycles, so the edge times can be written out directly. The bench sweeps eight abort causes: host release, removal on each presence input, and the five fault flags. It applies each cause in all four session phases and alternates the voltage class, then checks every deactivation edge, the interrupt level and the lockout. Separate sweeps cover all four presence-input combinations and each fault flag blocking a session start.

// File: rtl/scard_pkg.sv
package scard_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_IOEN, ST_CLKON, ST_LIVE,
    ST_DRST, ST_DCLK, ST_DIO, ST_LOCK
  } seq_st_t;
endpackage

// File: rtl/scard_fault_agg.sv
module scard_fault_agg #(
  parameter int NFLT = 5
) (
  input  logic            pres_hi_i,
  input  logic            pres_lo_n_i,
  input  logic [NFLT-1:0] flt_i,
  output logic            present_o,
  output logic            abort_o
);
  always_comb begin
    present_o = pres_hi_i | ~pres_lo_n_i;
    abort_o   = (|flt_i) | ~present_o;
  end
endmodule

// File: rtl/scard_step_timer.sv
module scard_step_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/scard_fsm.sv
module scard_fsm
  import scard_pkg::*;
#(
  parameter int ACT_GAP   = 16,
  parameter int DEACT_GAP = 4,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_n_i,
  input  logic          rst_lvl_i,
  input  logic          vsel_i,
  input  logic          present_i,
  input  logic          abort_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] val_o,
  output logic          vcc_en_o,
  output logic          vsel_o,
  output logic          io_en_o,
  output logic          clk_en_o,
  output logic          card_rst_o,
  output logic          irq_n_o
);
  localparam logic [CW-1:0] ACT_LD   = CW'(ACT_GAP - 1);
  localparam logic [CW-1:0] DEACT_LD = CW'(DEACT_GAP - 1);

  seq_st_t st_q, st_nxt;
  logic    lat_q, lat_nxt, in_sess, stop_req;

  always_comb begin
    in_sess  = (st_q != ST_IDLE) && (st_q != ST_LOCK);
    stop_req = abort_i | act_n_i;
    lat_nxt  = lat_q | (in_sess & abort_i);
    st_nxt   = st_q;
    case (st_q)
      ST_IDLE: begin
        lat_nxt = 1'b0;
        if (!act_n_i && !abort_i) st_nxt = ST_PWR;
      end
      ST_PWR:   if (stop_req) st_nxt = ST_DRST; else if (done_i) st_nxt = ST_IOEN;
      ST_IOEN:  if (stop_req) st_nxt = ST_DRST; else if (done_i) st_nxt = ST_CLKON;
      ST_CLKON: if (stop_req) st_nxt = ST_DRST; else if (done_i) st_nxt = ST_LIVE;
      ST_LIVE:  if (stop_req) st_nxt = ST_DRST;
      ST_DRST:  if (done_i) st_nxt = ST_DCLK;
      ST_DCLK:  if (done_i) st_nxt = ST_DIO;
      ST_DIO:   if (done_i) st_nxt = lat_nxt ? ST_LOCK : ST_IDLE;
      ST_LOCK: begin
        if (act_n_i) begin
          st_nxt  = ST_IDLE;
          lat_nxt = 1'b0;
        end
      end
      default: begin
        st_nxt  = ST_IDLE;
        lat_nxt = 1'b0;
      end
    endcase
    load_o = (st_nxt != st_q);
    val_o  = (st_nxt inside {ST_PWR, ST_IOEN, ST_CLKON}) ? ACT_LD : DEACT_LD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      lat_q      <= 1'b0;
      vcc_en_o   <= 1'b0;
      vsel_o     <= 1'b0;
      io_en_o    <= 1'b0;
      clk_en_o   <= 1'b0;
      card_rst_o <= 1'b0;
      irq_n_o    <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      lat_q      <= lat_nxt;
      vcc_en_o   <= (st_nxt inside {ST_PWR, ST_IOEN, ST_CLKON, ST_LIVE}) |
                    (vcc_en_o & (st_nxt inside {ST_DRST, ST_DCLK, ST_DIO}));
      io_en_o    <= (st_nxt inside {ST_IOEN, ST_CLKON, ST_LIVE}) |
                    (io_en_o & (st_nxt inside {ST_DRST, ST_DCLK}));
      clk_en_o   <= (st_nxt inside {ST_CLKON, ST_LIVE}) |
                    (clk_en_o & (st_nxt == ST_DRST));
      card_rst_o <= (st_nxt == ST_LIVE) & rst_lvl_i;
      if (st_q == ST_IDLE && st_nxt == ST_PWR) vsel_o <= vsel_i;
      irq_n_o    <= (st_nxt == ST_IDLE) ? present_i : ~lat_nxt;
    end
  end
endmodule

// File: rtl/scard_seq.sv
module scard_seq #(
  parameter int ACT_GAP   = 16,
  parameter int DEACT_GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_n_i,
  input  logic rst_lvl_i,
  input  logic vsel_i,
  input  logic pres_hi_i,
  input  logic pres_lo_n_i,
  input  logic flt_vcc_i,
  input  logic flt_vreg_i,
  input  logic flt_vdig_i,
  input  logic flt_ovc_i,
  input  logic flt_temp_i,
  output logic vcc_en_o,
  output logic vsel_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic irq_n_o
);
  localparam int NFLT = 5;
  localparam int MAXG = (ACT_GAP > DEACT_GAP) ? ACT_GAP : DEACT_GAP;
  localparam int CW   = $clog2(MAXG + 1);

  logic          present, abort_any, done, load;
  logic [CW-1:0] load_val;

  scard_fault_agg #(.NFLT(NFLT)) agg_i (
    .pres_hi_i   (pres_hi_i),
    .pres_lo_n_i (pres_lo_n_i),
    .flt_i       ({flt_temp_i, flt_ovc_i, flt_vdig_i, flt_vreg_i, flt_vcc_i}),
    .present_o   (present),
    .abort_o     (abort_any)
  );

  scard_step_timer #(.CW(CW)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .val_i  (load_val),
    .done_o (done)
  );

  scard_fsm #(.ACT_GAP(ACT_GAP), .DEACT_GAP(DEACT_GAP), .CW(CW)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .act_n_i    (act_n_i),
    .rst_lvl_i  (rst_lvl_i),
    .vsel_i     (vsel_i),
    .present_i  (present),
    .abort_i    (abort_any),
    .done_i     (done),
    .load_o     (load),
    .val_o      (load_val),
    .vcc_en_o   (vcc_en_o),
    .vsel_o     (vsel_o),
    .io_en_o    (io_en_o),
    .clk_en_o   (clk_en_o),
    .card_rst_o (card_rst_o),
    .irq_n_o    (irq_n_o)
  );
endmodule

// File: rtl/scard_seq_chk.sv
module scard_seq_chk (
  input logic clk,
  input logic rst,
  input logic act_n_i,
  input logic rst_lvl_i,
  input logic vsel_i,
  input logic pres_hi_i,
  input logic pres_lo_n_i,
  input logic flt_vcc_i,
  input logic flt_vreg_i,
  input logic flt_vdig_i,
  input logic flt_ovc_i,
  input logic flt_temp_i,
  input logic vcc_en_o,
  input logic vsel_o,
  input logic io_en_o,
  input logic clk_en_o,
  input logic card_rst_o,
  input logic irq_n_o
);
  logic bad;
  assign bad = flt_vcc_i | flt_vreg_i | flt_vdig_i | flt_ovc_i | flt_temp_i |
               ~(pres_hi_i | ~pres_lo_n_i);

  p_io_needs_vcc_r3: assert property (@(posedge clk) disable iff (rst)
    io_en_o |-> vcc_en_o);
  p_clk_needs_io_r5: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |-> io_en_o);
  p_rst_needs_clk_r4: assert property (@(posedge clk) disable iff (rst)
    card_rst_o |-> clk_en_o);
  p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!vcc_en_o && bad) |=> !vcc_en_o);
  p_abort_drops_rst_r6: assert property (@(posedge clk) disable iff (rst)
    bad |=> !card_rst_o);
  p_fault_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (vcc_en_o && bad) |=> !irq_n_o);
  p_vsel_held_r9: assert property (@(posedge clk) disable iff (rst)
    (vcc_en_o && $past(vcc_en_o)) |-> $stable(vsel_o));
endmodule

bind scard_seq scard_seq_chk chk_i (.*);

// File: tb/scard_seq_tb_top.sv
`timescale 1ns/1ps
module scard_seq_tb_top;
  localparam int AG = 3;
  localparam int DG = 2;

  logic clk = 1'b0;
  logic rst, act_n, rst_lvl, vsel, pres_hi, pres_lo_n;
  logic [4:0] flt;
  logic vcc_en, vsel_o, io_en, clk_en, card_rst, irq_n;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scard_seq #(.ACT_GAP(AG), .DEACT_GAP(DG)) dut_i (
    .clk(clk), .rst(rst), .act_n_i(act_n), .rst_lvl_i(rst_lvl), .vsel_i(vsel),
    .pres_hi_i(pres_hi), .pres_lo_n_i(pres_lo_n),
    .flt_vcc_i(flt[0]), .flt_vreg_i(flt[1]), .flt_vdig_i(flt[2]),
    .flt_ovc_i(flt[3]), .flt_temp_i(flt[4]),
    .vcc_en_o(vcc_en), .vsel_o(vsel_o), .io_en_o(io_en), .clk_en_o(clk_en),
    .card_rst_o(card_rst), .irq_n_o(irq_n)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b exp %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pres(input logic on, input logic lo_pin);
    if (lo_pin) begin pres_hi = 1'b0; pres_lo_n = ~on; end
    else        begin pres_hi = on;   pres_lo_n = 1'b1; end
  endtask

  // k: 0 host release, 1 removal (high pin), 2..6 fault flag k-2, 7 removal (low pin)
  task automatic run(input int k, input int ph, input logic vs);
    logic lo_pin;
    lo_pin = (k == 7) ? 1'b1 : ((k % 2) == 0);
    set_pres(1'b1, lo_pin);
    flt = '0; vsel = vs; rst_lvl = 1'b1;
    tick(1);
    act_n = 1'b0;
    tick(1);
    chk("R3 vcc on", vcc_en, 1'b1);
    chk("R3 io off", io_en, 1'b0);
    chk("R9 vsel cap", vsel_o, vs);
    chk("R7 irq in session", irq_n, 1'b1);
    vsel = ~vs;
    for (int s = 1; s <= ph; s++) begin
      tick(AG - 1);
      if (s == 1) chk("R3 io before gap", io_en, 1'b0);
      if (s == 2) chk("R3 clk before gap", clk_en, 1'b0);
      if (s == 3) chk("R4 rst held", card_rst, 1'b0);
      tick(1);
      if (s == 1) chk("R3 io on", io_en, 1'b1);
      if (s == 2) chk("R3 clk on", clk_en, 1'b1);
      if (s == 3) chk("R4 rst follows", card_rst, 1'b1);
    end
    if (ph == 3) begin
      rst_lvl = 1'b0; tick(1); chk("R4 rst low", card_rst, 1'b0);
      rst_lvl = 1'b1; tick(1); chk("R4 rst high", card_rst, 1'b1);
    end
    chk("R9 vsel held", vsel_o, vs);
    if (k == 0) act_n = 1'b1;
    else if (k == 1 || k == 7) set_pres(1'b0, lo_pin);
    else flt[k-2] = 1'b1;
    tick(1);
    chk("R5 R6 rst drop", card_rst, 1'b0);
    chk("R6 clk kept", clk_en, ph >= 2);
    chk("R6 io kept", io_en, ph >= 1);
    chk("R6 vcc kept", vcc_en, 1'b1);
    chk("R7 irq at abort", irq_n, k == 0);
    tick(DG);
    chk("R5 clk drop", clk_en, 1'b0);
    chk("R5 io still", io_en, ph >= 1);
    tick(DG);
    chk("R5 io drop", io_en, 1'b0);
    chk("R5 vcc still", vcc_en, 1'b1);
    tick(DG);
    chk("R5 vcc drop", vcc_en, 1'b0);
    if (k == 0) begin
      chk("R1 idle presence", irq_n, 1'b1);
    end else begin
      chk("R8 locked irq", irq_n, 1'b0);
      flt = '0; set_pres(1'b1, lo_pin);
      tick(4);
      chk("R8 no restart", vcc_en, 1'b0);
      chk("R8 irq held", irq_n, 1'b0);
      act_n = 1'b1;
      tick(1);
      chk("R8 unlock irq", irq_n, 1'b1);
    end
    chk("R9 vsel kept", vsel_o, vs);
    act_n = 1'b1;
    tick(2);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; act_n = 1'b1; rst_lvl = 1'b0; vsel = 1'b0;
    pres_hi = 1'b0; pres_lo_n = 1'b1; flt = '0;
    tick(3);
    chk("R1 reset vcc", vcc_en, 1'b0);
    chk("R1 reset io", io_en, 1'b0);
    chk("R1 reset clk", clk_en, 1'b0);
    chk("R1 reset rst", card_rst, 1'b0);
    chk("R1 reset irq", irq_n, 1'b0);
    rst = 1'b0;
    for (int p = 0; p < 4; p++) begin
      pres_hi = p[0]; pres_lo_n = p[1];
      tick(1);
      chk("R1 presence", irq_n, p[0] | ~p[1]);
    end
    // R2: no card
    set_pres(1'b0, 1'b0); act_n = 1'b0;
    tick(4);
    chk("R2 no card", vcc_en, 1'b0);
    chk("R1 no card irq", irq_n, 1'b0);
    act_n = 1'b1;
    set_pres(1'b1, 1'b0);
    for (int f = 0; f < 5; f++) begin
      flt = '0; flt[f] = 1'b1; act_n = 1'b0;
      tick(4);
      chk("R2 fault blocks", vcc_en, 1'b0);
      act_n = 1'b1; flt = '0;
      tick(1);
    end
    // R10: digital supply fault held, then released with command low
    flt[2] = 1'b1; act_n = 1'b0;
    tick(5);
    chk("R10 held off", vcc_en, 1'b0);
    flt[2] = 1'b0;
    tick(1);
    chk("R10 start after clear", vcc_en, 1'b1);
    act_n = 1'b1;
    tick(3 * DG + 2);
    chk("R5 off after release", vcc_en, 1'b0);
    for (int k = 0; k < 8; k++)
      for (int ph = 0; ph < 4; ph++)
        run(k, ph, ((k + ph) % 2) == 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule